// File: doc/BRIEF.md
# I2C Bus Wedge Fault Injector

This block is a test sequencer that drives an I2C bus through open-drain clock and data pins and deliberately abandons a target device in the middle of a transaction. It is meant to set up the stuck-bus situations that bus-recovery logic has to clear. After a command is taken, the block runs one of three fixed sequences. It can stop in the acknowledge slot of the address byte. It can stop part-way through a read that follows a register-pointer write. It can stop part-way through a register write. It then parks the bus with the clock released high and the data line released, and it never generates a stop condition.

Each bus phase uses the same timing as a bit-level master. A settle delay of `SETTLE_CYC` clocks follows every line change. Each release of the clock waits for the line to read high, up to `STRETCH_CYC` clocks, so a target can hold the clock low to stretch it. When the final clock release settles, the block raises `done` and reports the data and clock levels it sampled. A timeout or a lost line during the sequence is recorded in a sticky flag. Such an error does not abort the run, which always reaches the parked state.

Top module: `wdg_injector`

## Requirements
- R1: A command is accepted only while `busy` is low, and only with `cmd_mode` 0 (address wedge), 1 (read wedge) or 2 (write wedge). `busy` is high from the clock after acceptance until parking. Mode 3, and any command presented while busy, are ignored.
- R2: Mode 0 sends a start, then the 7 address bits most significant first, then a 0 direction bit. The block then releases the data line and the clock and parks. The acknowledge slot is never clocked low.
- R3: Mode 1 runs these steps in order, with each acknowledge slot clocked with data released:
  - a start;
  - the address with direction 0, then its acknowledge slot;
  - the 8 bits of `cmd_reg`, then their acknowledge slot;
  - a repeated start;
  - the address with direction 1, then its acknowledge slot;
  - `cmd_bits` data bits (0 to 15) clocked in with data released;
  - parking.
- R4: Mode 2 sends a start, the address with direction 0 and its acknowledge slot. It then sends the top `min(cmd_bits,8)` bits of `cmd_reg`, most significant first, and parks.
- R5: When parked, `scl_oe` and `sda_oe` are both 0 and `done` is 1. `park_sda` and `park_scl` give the line levels read after the final clock release. `done` holds until the next accepted command and is never high together with `busy`.
- R6: No stop condition is produced in any mode. The block releases the data line only while it drives the clock low.
- R7: If the clock stays low for `STRETCH_CYC` clocks after a release, `err_timeout` is set and the sequence continues to the parked state.
- R8: If the data line reads low when it should be high, `err_arb` is set and the sequence continues. This is checked before a start and before and after a 1 bit is clocked.
- R9: Both error flags stay set until the next accepted command, which clears them.
- R10: While `rst` (synchronous, active high) is applied, both lines are released and `busy`, `done` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 2 | 0 address wedge, 1 read wedge, 2 write wedge |
| cmd_addr | input | 7 | Target address |
| cmd_reg | input | 8 | Register byte |
| cmd_bits | input | 4 | Bit count for read or write wedge |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | 1 drives the clock line low |
| sda_oe | output | 1 | 1 drives the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Bus parked |
| park_scl | output | 1 | Clock level read at parking |
| park_sda | output | 1 | Data level read at parking |
| err_timeout | output | 1 | Sticky clock-stretch timeout |
| err_arb | output | 1 | Sticky data-line-low error |

## Verification
Each mode is run with several address and register patterns, and every clocked bit is recorded from the bus lines and compared with the expected stream. The patterns include alternating bits, a single set bit and all ones, so a bit-order or direction-bit slip shows up. For the read and write modes the bit count is set to zero, to a mid value, to the maximum and, for writes, to a value above eight. These separate the clamp, the empty-count path and the read-side repeated start. A clock held low, a data line held low, a command presented while busy, a reserved mode and a reset during a run tell the error, ignore and reset behaviour apart from the normal path.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = 4;
    localparam int SEG_W  = 4;

    typedef enum logic [1:0] {
        MODE_ACK   = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_OUT   = 2'd1,
        OP_IN    = 2'd2,
        OP_PARK  = 2'd3
    } op_e;
endpackage

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wdg_plan.sv
module wdg_plan
    import wdg_pkg::*;
(
    input  mode_e             mode,
    input  logic [SEG_W-1:0]  seg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] rbyte,
    input  logic [CNT_W-1:0]  cnt,
    output op_e               kind,
    output logic [BYTE_W-1:0] obyte,
    output logic [CNT_W-1:0]  nbits
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [CNT_W-1:0] wr_cnt;
    assign wr_cnt = (cnt > FULL) ? FULL : cnt;

    always_comb begin
        kind  = OP_PARK;
        obyte = '0;
        nbits = '0;
        unique case (mode)
            MODE_READ: begin
                unique case (seg)
                    4'd0: kind = OP_START;
                    4'd1: begin kind = OP_OUT; obyte = {addr, 1'b0}; nbits = FULL; end
                    4'd2: begin kind = OP_IN;  nbits = 1; end
                    4'd3: begin kind = OP_OUT; obyte = rbyte; nbits = FULL; end
                    4'd4: begin kind = OP_IN;  nbits = 1; end
                    4'd5: kind = OP_START;
                    4'd6: begin kind = OP_OUT; obyte = {addr, 1'b1}; nbits = FULL; end
                    4'd7: begin kind = OP_IN;  nbits = 1; end
                    4'd8: begin kind = OP_IN;  nbits = cnt; end
                    default: kind = OP_PARK;
                endcase
            end
            MODE_WRITE: begin
                unique case (seg)
                    4'd0: kind = OP_START;
                    4'd1: begin kind = OP_OUT; obyte = {addr, 1'b0}; nbits = FULL; end
                    4'd2: begin kind = OP_IN;  nbits = 1; end
                    4'd3: begin kind = OP_OUT; obyte = rbyte; nbits = wr_cnt; end
                    default: kind = OP_PARK;
                endcase
            end
            default: begin
                unique case (seg)
                    4'd0: kind = OP_START;
                    4'd1: begin kind = OP_OUT; obyte = {addr, 1'b0}; nbits = FULL; end
                    default: kind = OP_PARK;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/wdg_bit_engine.sv
module wdg_bit_engine
    import wdg_pkg::*;
#(
    parameter int SETTLE_CYC  = 4,
    parameter int STRETCH_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  op_e  op,
    input  logic obit,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic fin,
    output logic fin_err_to,
    output logic fin_err_arb,
    output logic lvl_scl,
    output logic lvl_sda
);
    localparam int MAXC = (STRETCH_CYC > SETTLE_CYC) ? STRETCH_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] T_SETTLE  = TW'(SETTLE_CYC);
    localparam logic [TW-1:0] T_STRETCH = TW'(STRETCH_CYC);

    typedef enum logic [2:0] {E_IDLE, E_SETUP, E_RISE, E_HIGH, E_SDALOW, E_FIN} est_e;

    typedef struct packed {
        est_e st;
        op_e  op;
        logic obit;
        logic scl_oe;
        logic sda_oe;
        logic err_to;
        logic err_arb;
        logic lvl_scl;
        logic lvl_sda;
    } eng_t;

    eng_t          e_d, e_q;
    logic          t_load, t_exp;
    logic [TW-1:0] t_val;

    wdg_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    always_comb begin
        e_d    = e_q;
        t_load = 1'b0;
        t_val  = T_SETTLE;
        unique case (e_q.st)
            E_IDLE: if (go) begin
                e_d.op      = op;
                e_d.obit    = obit;
                e_d.err_to  = 1'b0;
                e_d.err_arb = 1'b0;
                e_d.sda_oe  = (op == OP_OUT) ? ~obit : 1'b0;
                t_load      = 1'b1;
                e_d.st      = E_SETUP;
            end
            E_SETUP: if (t_exp) begin
                if (e_q.op == OP_OUT && e_q.obit && !sda_in) e_d.err_arb = 1'b1;
                e_d.scl_oe = 1'b0;
                t_load     = 1'b1;
                t_val      = T_STRETCH;
                e_d.st     = E_RISE;
            end
            E_RISE: if (scl_in || t_exp) begin
                if (!scl_in) e_d.err_to = 1'b1;
                if (e_q.op == OP_PARK) begin
                    e_d.lvl_scl = scl_in;
                    e_d.lvl_sda = sda_in;
                    e_d.st      = E_FIN;
                end else begin
                    t_load = 1'b1;
                    e_d.st = E_HIGH;
                end
            end
            E_HIGH: if (t_exp) begin
                if (e_q.op == OP_START) begin
                    if (!sda_in) e_d.err_arb = 1'b1;
                    e_d.sda_oe = 1'b1;
                    t_load     = 1'b1;
                    e_d.st     = E_SDALOW;
                end else begin
                    if (e_q.op == OP_OUT && e_q.obit && !sda_in) e_d.err_arb = 1'b1;
                    e_d.scl_oe = 1'b1;
                    e_d.st     = E_FIN;
                end
            end
            E_SDALOW: if (t_exp) begin
                e_d.scl_oe = 1'b1;
                e_d.st     = E_FIN;
            end
            default: e_d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q         <= '0;
            e_q.st      <= E_IDLE;
            e_q.lvl_scl <= 1'b1;
            e_q.lvl_sda <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign scl_oe      = e_q.scl_oe;
    assign sda_oe      = e_q.sda_oe;
    assign fin         = (e_q.st == E_FIN);
    assign fin_err_to  = e_q.err_to;
    assign fin_err_arb = e_q.err_arb;
    assign lvl_scl     = e_q.lvl_scl;
    assign lvl_sda     = e_q.lvl_sda;
endmodule

// File: rtl/wdg_injector.sv
module wdg_injector
    import wdg_pkg::*;
#(
    parameter int SETTLE_CYC  = 250,
    parameter int STRETCH_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_mode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              done,
    output logic              park_scl,
    output logic              park_sda,
    output logic              err_timeout,
    output logic              err_arb
);
    localparam int BIDX_W = $clog2(BYTE_W);
    localparam logic [BIDX_W-1:0] TOP_BIT = BIDX_W'(BYTE_W - 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} sst_e;

    typedef struct packed {
        sst_e              st;
        mode_e             mode;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] rbyte;
        logic [CNT_W-1:0]  cnt;
        logic [SEG_W-1:0]  seg;
        logic [CNT_W-1:0]  bidx;
        logic              done;
        logic              park_scl;
        logic              park_sda;
        logic              err_to;
        logic              err_arb;
    } seq_t;

    seq_t s_d, s_q;

    op_e               pl_kind;
    logic [BYTE_W-1:0] pl_byte;
    logic [CNT_W-1:0]  pl_nbits;
    logic              go, obit;
    logic              e_fin, e_to, e_arb, e_lscl, e_lsda;

    wdg_plan u_plan (
        .mode(s_q.mode), .seg(s_q.seg), .addr(s_q.addr), .rbyte(s_q.rbyte),
        .cnt(s_q.cnt), .kind(pl_kind), .obyte(pl_byte), .nbits(pl_nbits)
    );

    wdg_bit_engine #(.SETTLE_CYC(SETTLE_CYC), .STRETCH_CYC(STRETCH_CYC)) u_eng (
        .clk(clk), .rst(rst), .go(go), .op(pl_kind), .obit(obit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .fin(e_fin), .fin_err_to(e_to), .fin_err_arb(e_arb),
        .lvl_scl(e_lscl), .lvl_sda(e_lsda)
    );

    assign obit = pl_byte[TOP_BIT - s_q.bidx[BIDX_W-1:0]];

    always_comb begin
        s_d = s_q;
        go  = 1'b0;
        unique case (s_q.st)
            S_IDLE, S_DONE: begin
                if (cmd_valid && cmd_mode != MODE_RSVD) begin
                    s_d.mode    = mode_e'(cmd_mode);
                    s_d.addr    = cmd_addr;
                    s_d.rbyte   = cmd_reg;
                    s_d.cnt     = cmd_bits;
                    s_d.seg     = '0;
                    s_d.bidx    = '0;
                    s_d.done    = 1'b0;
                    s_d.err_to  = 1'b0;
                    s_d.err_arb = 1'b0;
                    s_d.st      = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if ((pl_kind == OP_OUT || pl_kind == OP_IN) && pl_nbits == '0) begin
                    s_d.seg = s_q.seg + 1'b1;
                end else begin
                    go     = 1'b1;
                    s_d.st = S_WAIT;
                end
            end
            default: begin
                if (e_fin) begin
                    s_d.err_to  = s_q.err_to | e_to;
                    s_d.err_arb = s_q.err_arb | e_arb;
                    s_d.st      = S_ISSUE;
                    if (pl_kind == OP_PARK) begin
                        s_d.park_scl = e_lscl;
                        s_d.park_sda = e_lsda;
                        s_d.done     = 1'b1;
                        s_d.st       = S_DONE;
                    end else if (pl_kind == OP_START) begin
                        s_d.seg = s_q.seg + 1'b1;
                    end else if (s_q.bidx + 1'b1 == pl_nbits) begin
                        s_d.seg  = s_q.seg + 1'b1;
                        s_d.bidx = '0;
                    end else begin
                        s_d.bidx = s_q.bidx + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q          <= '0;
            s_q.st       <= S_IDLE;
            s_q.park_scl <= 1'b1;
            s_q.park_sda <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st == S_ISSUE) || (s_q.st == S_WAIT);
    assign done        = s_q.done;
    assign park_scl    = s_q.park_scl;
    assign park_sda    = s_q.park_sda;
    assign err_timeout = s_q.err_to;
    assign err_arb     = s_q.err_arb;
endmodule

// File: rtl/wdg_injector_chk.sv
module wdg_injector_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_mode,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       done,
    input logic       err_timeout,
    input logic       err_arb
);
    logic take;
    assign take = cmd_valid && !busy && (cmd_mode != 2'd3);

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

    p_reject_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(cmd_valid && cmd_mode != 2'd3)) |=> !busy);

    p_park_released_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_oe && !sda_oe));

    p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_valid) |=> done);

    p_no_stop_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> scl_oe);

    p_to_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_timeout && !take) |=> err_timeout);

    p_arb_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (err_arb && !take) |=> err_arb);

    p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
        take |=> (!err_timeout && !err_arb));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!busy && !done && !scl_oe && !sda_oe && !err_timeout && !err_arb));
endmodule

bind wdg_injector wdg_injector_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_arb(err_arb)
);

// File: tb/tb_wdg_injector.sv
module tb_wdg_injector;
    localparam int SET = 3;
    localparam int STR = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_mode = '0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_reg = '0;
    logic [3:0] cmd_bits = '0;
    logic tgt_scl_low = 1'b0;
    logic tgt_sda_low = 1'b0;
    logic scl_oe, sda_oe, busy, done, park_scl, park_sda, err_timeout, err_arb;
    logic scl_ln, sda_ln;

    assign scl_ln = !scl_oe && !tgt_scl_low;
    assign sda_ln = !sda_oe && !tgt_sda_low;

    always #2 clk = ~clk;

    wdg_injector #(.SETTLE_CYC(SET), .STRETCH_CYC(STR)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_bits(cmd_bits),
        .scl_in(scl_ln), .sda_in(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .park_scl(park_scl), .park_sda(park_sda),
        .err_timeout(err_timeout), .err_arb(err_arb)
    );

    int checks = 0;
    int errors = 0;

    // bus monitor: start, stop, and one data bit per clock fall (the fall closing a start is skipped)
    logic p_scl = 1'b1, p_sda = 1'b1, in_st = 1'b0;
    int rec_n = 0, n_start = 0, n_stop = 0;
    logic rec_arr [0:2047];

    always @(posedge clk) begin
        #1;
        if (p_scl && scl_ln && p_sda && !sda_ln) begin n_start++; in_st = 1'b1; end
        else if (p_scl && scl_ln && !p_sda && sda_ln) n_stop++;
        if (p_scl && !scl_ln) begin
            if (in_st) in_st = 1'b0;
            else begin
                if (rec_n < 2048) rec_arr[rec_n] = sda_ln;
                rec_n++;
            end
        end
        p_scl = scl_ln;
        p_sda = sda_ln;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected bit stream with an idle target: acknowledge slots and read data read as 1
    function automatic void build_exp(input logic [1:0] m, input logic [6:0] a,
                                      input logic [7:0] r, input logic [3:0] c,
                                      output logic [63:0] e, output int n, output int s);
        e = '0; n = 0; s = 1;
        for (int i = 6; i >= 0; i--) begin e[n] = a[i]; n++; end
        e[n] = 1'b0; n++;
        if (m == 2'd1) begin
            e[n] = 1'b1; n++;
            for (int i = 7; i >= 0; i--) begin e[n] = r[i]; n++; end
            e[n] = 1'b1; n++;
            s = 2;
            for (int i = 6; i >= 0; i--) begin e[n] = a[i]; n++; end
            e[n] = 1'b1; n++;
            e[n] = 1'b1; n++;
            for (int i = 0; i < 16; i++) if (i < int'(c)) begin e[n] = 1'b1; n++; end
        end else if (m == 2'd2) begin
            e[n] = 1'b1; n++;
            for (int i = 0; i < 8; i++) if (i < int'(c)) begin e[n] = r[7-i]; n++; end
        end
    endfunction

    task automatic run_cmd(input logic [1:0] m, input logic [6:0] a, input logic [7:0] r,
                           input logic [3:0] c, output bit bsy, output bit fin);
        @(negedge clk);
        cmd_mode = m; cmd_addr = a; cmd_reg = r; cmd_bits = c; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bsy = busy;
        fin = 1'b0;
        for (int i = 0; i < 20000 && !fin; i++) begin
            @(negedge clk);
            if (done) fin = 1'b1;
        end
    endtask

    task automatic check_stream(input string tag, input logic [1:0] m, input logic [6:0] a,
                                input logic [7:0] r, input logic [3:0] c,
                                input int base_n, input int base_s, input int base_p,
                                input int tab_s, input int tab_n);
        logic [63:0] e, got;
        int n, s;
        bit same;
        build_exp(m, a, r, c, e, n, s);
        got = '0;
        same = 1'b1;
        for (int i = 0; i < n && i < 64; i++) begin
            got[i] = rec_arr[base_n + i];
            if (got[i] !== e[i]) same = 1'b0;
        end
        chk(rec_n - base_n == tab_n && n == tab_n, {tag, " bit count"}, rec_n - base_n, tab_n);
        chk(same, {tag, " bit stream"}, got, e);
        chk(n_start - base_s == tab_s && s == tab_s, {tag, " starts"}, n_start - base_s, tab_s);
        chk(n_stop == base_p, "R6 no stop during sequence", n_stop - base_p, 0);
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic [6:0] addr;
        logic [7:0] rg;
        logic [3:0] cnt;
        logic [1:0] starts;
        logic [5:0] nbits;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 7'h5A, 8'h00, 4'd0,  2'd1, 6'd8},
        '{2'd0, 7'h01, 8'hFF, 4'd7,  2'd1, 6'd8},
        '{2'd1, 7'h50, 8'hA5, 4'd3,  2'd2, 6'd30},
        '{2'd1, 7'h2B, 8'h01, 4'd0,  2'd2, 6'd27},
        '{2'd1, 7'h7F, 8'h80, 4'd15, 2'd2, 6'd42},
        '{2'd2, 7'h2C, 8'hC3, 4'd5,  2'd1, 6'd14},
        '{2'd2, 7'h33, 8'h96, 4'd12, 2'd1, 6'd17},
        '{2'd2, 7'h40, 8'h6E, 4'd0,  2'd1, 6'd9}
    };

    initial begin
        bit bsy, fin;
        int bn, bs, bp;
        string tag;

        repeat (4) @(negedge clk);
        // R10: state during reset
        chk(!busy && !done && !scl_oe && !sda_oe && !err_timeout && !err_arb,
            "R10 reset state", {busy, done, scl_oe, sda_oe, err_timeout, err_arb}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: mode 3 is not accepted
        cmd_mode = 2'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !scl_oe && !sda_oe, "R1 mode 3 ignored", {busy, done}, 0);

        // vector table: R2 address wedge, R3 read wedge, R4 write wedge
        foreach (VECS[k]) begin
            tag = (VECS[k].mode == 2'd0) ? "R2" : (VECS[k].mode == 2'd1) ? "R3" : "R4";
            bn = rec_n; bs = n_start; bp = n_stop;
            run_cmd(VECS[k].mode, VECS[k].addr, VECS[k].rg, VECS[k].cnt, bsy, fin);
            chk(bsy, "R1 busy after accept", bsy, 1);
            chk(fin, {tag, " reaches park"}, fin, 1);
            check_stream(tag, VECS[k].mode, VECS[k].addr, VECS[k].rg, VECS[k].cnt,
                         bn, bs, bp, int'(VECS[k].starts), int'(VECS[k].nbits));
            chk(!scl_oe && !sda_oe && park_scl && park_sda && !busy,
                "R5 parked lines and levels", {scl_oe, sda_oe, park_scl, park_sda, busy}, 5'b00110);
            chk(!err_timeout && !err_arb, "R7 R8 no error on clean run", {err_timeout, err_arb}, 0);
            repeat (6) @(negedge clk);
            chk(done && scl_ln && sda_ln, "R5 done holds while parked", {done, scl_ln, sda_ln}, 3'b111);
        end

        // R1: a command presented while busy is ignored
        bn = rec_n; bs = n_start; bp = n_stop;
        @(negedge clk);
        cmd_mode = 2'd1; cmd_addr = 7'h50; cmd_reg = 8'hA5; cmd_bits = 4'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd_mode = 2'd0; cmd_addr = 7'h11; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        fin = 1'b0;
        for (int i = 0; i < 20000 && !fin; i++) begin
            @(negedge clk);
            if (done) fin = 1'b1;
        end
        check_stream("R1 busy-ignore", 2'd1, 7'h50, 8'hA5, 4'd3, bn, bs, bp, 2, 30);

        // R7: clock held low by the target
        tgt_scl_low = 1'b1;
        run_cmd(2'd0, 7'h22, 8'h00, 4'd0, bsy, fin);
        chk(fin, "R7 parks despite timeout", fin, 1);
        chk(err_timeout && !err_arb, "R7 timeout flag", {err_timeout, err_arb}, 2'b10);
        chk(!park_scl && park_sda, "R7 park levels", {park_scl, park_sda}, 2'b01);
        tgt_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        chk(err_timeout, "R9 timeout flag sticky", err_timeout, 1);

        // R8: data held low by the target
        tgt_sda_low = 1'b1;
        run_cmd(2'd0, 7'h7F, 8'h00, 4'd0, bsy, fin);
        chk(fin, "R8 parks despite data error", fin, 1);
        chk(err_arb && !err_timeout, "R8 data error flag, R9 timeout cleared",
            {err_timeout, err_arb}, 2'b01);
        chk(park_scl && !park_sda, "R8 park levels", {park_scl, park_sda}, 2'b10);
        tgt_sda_low = 1'b0;
        repeat (4) @(negedge clk);

        // R9: a new command clears the flags
        run_cmd(2'd0, 7'h5A, 8'h00, 4'd0, bsy, fin);
        chk(fin && !err_arb && !err_timeout, "R9 flags cleared by new command",
            {fin, err_timeout, err_arb}, 3'b100);

        // R10: reset in the middle of a read wedge
        @(negedge clk);
        cmd_mode = 2'd1; cmd_addr = 7'h3C; cmd_reg = 8'h55; cmd_bits = 4'd4; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy, "R10 busy before mid-run reset", busy, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !scl_oe && !sda_oe && !err_timeout && !err_arb,
            "R10 mid-run reset", {busy, done, scl_oe, sda_oe, err_timeout, err_arb}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && scl_ln && sda_ln, "R10 idle after reset", {busy, done, scl_ln, sda_ln}, 4'b0011);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule